// File: doc/BRIEF.md
# Power-On Comparator Offset Trim Sequencer

This block runs once after reset to give each comparator in a small bank a coarse offset trim. While it runs it places the converter in calibration mode. It closes the switch that ties the two DAC halves together, so every comparator sees a zero differential input. It drives every settling delay-line code to all ones and asks for a slow conversion clock. On each strobe of `dec_valid` it reads the decision of the comparator it is trimming. No other stimulus is needed.

The comparators are trimmed one after another: the four most significant comparators (indices 0 to 3), then the reference comparator (index 4). Each one gets a sign-magnitude trim word, found by a successive-approximation search that starts at the top bit. Every bit of that search is settled by a majority vote over a fixed number of decisions. After the last comparator the block releases the short, the delay override and the slow-clock request. It then raises `done`, which stays high until the next reset.

Top module: `trim_seq`

## Requirements
- R1: A synchronous active-high `rst` clears all five trim words to zero, clears `done` and restarts the sequence from comparator 0. The reset applies mid-sequence as well as at power-up.
- R2: While `done` is low, `short_en` and `slow_req` are 1 and every 3-bit field of `dly_code` is 7, whatever `dly_norm` holds.
- R3: Once `done` is high, `short_en` and `slow_req` are 0 and `dly_code` equals `dly_norm`. `done` then stays high and all trim words stay constant until reset, whatever `dec_valid` and `cmp_dec` do.
- R4: Trim word k sits at `trim_flat[5k+4:5k]`. Bit 4 is the sign (1 means the correction is subtracted) and bits 3:0 are the magnitude.
- R5: For each comparator the search takes five steps. The sign step is taken with the trim word at zero, and the sign bit becomes the majority decision. Magnitude bits 3, 2, 1 and 0 are then tried in turn, each presented as 1 on the output during its step. A tried bit is kept only when the majority decision equals the sign bit.
- R6: Each step uses exactly 16 decisions, counted only in cycles where `dec_valid` is 1. The majority is 1 only when more than 8 of the 16 are 1, so an 8/8 tie counts as 0.
- R7: Comparators are handled in the order 0, 1, 2, 3, 4. Only the bit of `cmp_dec` for the comparator being trimmed is counted.
- R8: Assume a comparator that outputs 1 exactly when (offset + signed trim) > 0, with the offset an integer in LSB units. Its final word is then sign 1 with magnitude min(offset−1, 15) for a positive offset, and sign 0 with magnitude min(−offset, 15) otherwise. Up to 7 wrong decisions per step do not change this result.
- R9: `done` rises in the cycle after the 400th accepted decision, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; restarts calibration |
| dec_valid | input | 1 | Strobe: `cmp_dec` holds the decisions of one zero-input conversion |
| cmp_dec | input | 5 | Decision of each comparator; bits 0-3 are the MSB comparators, bit 4 is the reference |
| dly_norm | input | 24 | Delay-line codes for normal operation, 3 bits per line |
| short_en | output | 1 | Closes the DAC-halves shorting switch |
| slow_req | output | 1 | Requests the reduced conversion clock |
| dly_code | output | 24 | Delay-line codes sent to the delay lines |
| trim_flat | output | 25 | Five 5-bit sign-magnitude trim words |
| done | output | 1 | Calibration finished; sticky until reset |

## Verification
The hardest case to reach from the ports is a step where the decisions nearly balance. This covers both a tie of exactly 8 ones and a true majority carried by only 9 of 16 votes. A stable comparator never produces it. The bench therefore models each comparator from its own trim output and counts accepted strobes to know where each 16-decision window begins. It can then flip the first 7 decisions of every window, or make a comparator alternate to force a tie. Offsets are swept past the saturation limits in both directions, with idle cycles carrying garbage decisions placed between strobes.

// File: rtl/trim_seq.sv
module trim_seq #(
  parameter int NCMP = 5,
  parameter int TW   = 5,
  parameter int SAMP = 16,
  parameter int NDLY = 8,
  parameter int DW   = 3
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 dec_valid,
  input  logic [NCMP-1:0]      cmp_dec,
  input  logic [NDLY*DW-1:0]   dly_norm,
  output logic                 short_en,
  output logic                 slow_req,
  output logic [NDLY*DW-1:0]   dly_code,
  output logic [NCMP*TW-1:0]   trim_flat,
  output logic                 done
);

  localparam int TGW = $clog2(NCMP);
  localparam int BW  = $clog2(TW);
  localparam int SCW = $clog2(SAMP);
  localparam int CW  = $clog2(SAMP + 1);
  localparam logic [BW-1:0] SIGN_IDX = BW'(TW - 1);

  logic [TW-1:0]  trim_q [NCMP];
  logic [TGW-1:0] tgt;
  logic [BW-1:0]  bidx;
  logic [SCW-1:0] cnt;
  logic [CW-1:0]  ones;

  logic [CW-1:0] ones_nxt;
  logic          last_samp, high, keep;
  logic [TW-1:0] trial;

  assign ones_nxt  = ones + CW'(cmp_dec[tgt]);
  assign last_samp = (cnt == SCW'(SAMP - 1));
  assign high      = (ones_nxt > CW'(SAMP / 2));
  assign keep      = (bidx == SIGN_IDX) ? high : (high == trim_q[tgt][TW-1]);
  assign trial     = (bidx == SIGN_IDX) ? '0 : (TW'(1) << bidx);

  assign short_en = ~done;
  assign slow_req = ~done;
  assign dly_code = done ? dly_norm : '1;

  for (genvar g = 0; g < NCMP; g++) begin : g_trim
    assign trim_flat[g*TW +: TW] =
      (!done && tgt == TGW'(g)) ? (trim_q[g] | trial) : trim_q[g];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NCMP; i++) trim_q[i] <= '0;
      tgt  <= '0;
      bidx <= SIGN_IDX;
      cnt  <= '0;
      ones <= '0;
      done <= 1'b0;
    end else if (!done && dec_valid) begin
      if (last_samp) begin
        cnt  <= '0;
        ones <= '0;
        trim_q[tgt][bidx] <= keep;
        if (bidx == '0) begin
          bidx <= SIGN_IDX;
          if (tgt == TGW'(NCMP - 1)) done <= 1'b1;
          else                       tgt  <= tgt + 1'b1;
        end else begin
          bidx <= bidx - 1'b1;
        end
      end else begin
        cnt  <= cnt + 1'b1;
        ones <= ones_nxt;
      end
    end
  end

  a_r3_done_sticky: assert property (@(posedge clk) disable iff (rst)
    done |=> done);

  a_r3_trims_frozen: assert property (@(posedge clk) disable iff (rst)
    (done && $past(done)) |-> $stable(trim_flat));

  a_r6_count_needs_valid: assert property (@(posedge clk) disable iff (rst)
    !dec_valid |=> $stable(cnt) && $stable(ones));

  a_r5_step_on_full_window: assert property (@(posedge clk) disable iff (rst)
    !$stable(bidx) |-> $past(dec_valid && last_samp));

  a_r7_target_in_order: assert property (@(posedge clk) disable iff (rst)
    !$stable(tgt) |-> (tgt == $past(tgt) + 1'b1));

  a_r2_cal_outputs: assert property (@(posedge clk) disable iff (rst)
    $fell(done) |-> short_en && slow_req);

endmodule

// File: tb/sim_trim_seq.sv
module sim_trim_seq;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        dec_valid = 1'b0;
  logic [4:0]  cmp_dec = '0;
  logic [23:0] dly_norm = 24'h5A3C96;
  logic        short_en, slow_req, done;
  logic [23:0] dly_code;
  logic [24:0] trim_flat;

  int n_tests = 0;
  int n_fail  = 0;
  int offs[5];
  int mode[5];
  int sent;

  always #2 clk = ~clk;

  trim_seq u0 (
    .clk(clk), .rst(rst), .dec_valid(dec_valid), .cmp_dec(cmp_dec),
    .dly_norm(dly_norm), .short_en(short_en), .slow_req(slow_req),
    .dly_code(dly_code), .trim_flat(trim_flat), .done(done)
  );

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic bit model(int o, logic [4:0] t, int m, int idx);
    int  eff;
    bit  d;
    eff = t[4] ? o - int'(t[3:0]) : o + int'(t[3:0]);
    d = eff > 0;
    if (m == 2) return bit'(idx % 2);
    if (m == 1 && idx < 7) return !d;
    return d;
  endfunction

  function automatic logic [4:0] expect_trim(int o, int m);
    int mag;
    if (m == 2) return 5'b01111;
    if (o > 0) begin
      mag = (o - 1 > 15) ? 15 : o - 1;
      return {1'b1, 4'(mag)};
    end
    mag = (-o > 15) ? 15 : -o;
    return {1'b0, 4'(mag)};
  endfunction

  task automatic do_reset();
    @(posedge clk); #1;
    rst = 1'b1; dec_valid = 1'b0;
    @(posedge clk); #1;
    @(posedge clk); #1;
    check(trim_flat == '0, "R1", "trims after reset", trim_flat, 0);
    check(done == 1'b0 && short_en && slow_req, "R1", "cal state after reset",
          {done, short_en, slow_req}, 3'b011);
    rst = 1'b0;
    sent = 0;
  endtask

  task automatic send_one(bit v);
    @(posedge clk); #1;
    dec_valid = v;
    if (v) begin
      for (int i = 0; i < 5; i++)
        cmp_dec[i] = model(offs[i], trim_flat[i*5 +: 5], mode[i], sent % 16);
      sent++;
    end else begin
      cmp_dec = 5'($urandom);
    end
  endtask

  task automatic run_cal(int gap);
    bit cal_ok = 1'b1;
    logic [24:0] snap;
    do_reset();
    for (int n = 0; n < 400; n++) begin
      if (gap != 0 && (n % gap) == 1) begin
        send_one(1'b0);
        if (!(short_en && slow_req && dly_code == 24'hFFFFFF && !done)) cal_ok = 1'b0;
      end
      send_one(1'b1);
      if (!(short_en && slow_req && dly_code == 24'hFFFFFF && !done)) cal_ok = 1'b0;
    end
    check(cal_ok, "R2", "calibration-mode outputs during run", 0, 1);
    check(done == 1'b0, "R9", "done before last decision registered", done, 0);
    send_one(1'b0);
    check(done == 1'b1, "R9", "done after 400th decision", done, 1);
    check(!short_en && !slow_req && dly_code == dly_norm, "R3", "normal outputs",
          dly_code, dly_norm);
    for (int i = 0; i < 5; i++)
      check(trim_flat[i*5 +: 5] == expect_trim(offs[i], mode[i]), "R8",
            $sformatf("trim word %0d (R4 R5 R6 R7)", i),
            trim_flat[i*5 +: 5], expect_trim(offs[i], mode[i]));
    snap = trim_flat;
    for (int k = 0; k < 40; k++) begin
      @(posedge clk); #1;
      dec_valid = 1'b1;
      cmp_dec = 5'($urandom);
    end
    @(posedge clk); #1;
    dec_valid = 1'b0;
    check(done && trim_flat == snap, "R3", "done and trims hold after finish",
          trim_flat, snap);
  endtask

  initial begin
    #800000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 5; i++) begin offs[i] = 0; mode[i] = 0; end
    for (int v = -9; v <= 9; v++) begin
      for (int i = 0; i < 5; i++) begin
        offs[i] = 2 * v + i - 2;
        mode[i] = 0;
      end
      dly_norm = 24'(32'h13579B * (v + 10));
      run_cal((v + 9) % 4);
    end
    for (int v = -3; v <= 3; v++) begin
      for (int i = 0; i < 5; i++) begin
        offs[i] = 5 * v - i;
        mode[i] = 1;
      end
      run_cal(3);
    end
    offs = '{3, -4, 6, 0, 1};
    mode = '{0, 0, 2, 0, 0};
    run_cal(2);
    for (int i = 0; i < 5; i++) begin offs[i] = 7; mode[i] = 0; end
    do_reset();
    for (int n = 0; n < 100; n++) send_one(1'b1);
    @(posedge clk); #1;
    rst = 1'b1; dec_valid = 1'b0;
    @(posedge clk); #1;
    check(trim_flat == '0 && !done && short_en, "R1", "mid-run reset clears",
          trim_flat, 0);
    offs = '{-15, 16, -1, 1, 9};
    run_cal(0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule